// File: doc/BRIEF.md
# Burst Address Sequencer with Order Select

This block produces the two low address bits for a four-beat burst access. When a new access starts, a load strobe captures a two-bit starting offset. Each later clock edge with the advance input high steps the burst forward by one beat. The address sequence follows one of two orders, chosen by a static strap bit.

In interleaved order, the address is the start offset XORed with a beat count. In linear order, the address is the start offset plus the beat count, modulo four. In both orders the pattern wraps back to the start offset after the fourth beat and repeats. An edge without advance holds the address, which suspends the burst. A flag marks the fourth beat so that the surrounding logic can tell where the burst ends.

The upper address bits, chip-select decoding and the storage array are handled by neighbouring logic. The address and flag come from registered state through a small amount of combinational mapping, so they change right after the clock edge that updates the state.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (rst_i high at a rising edge) sets addr_o to 00 and last_o to 0, and it overrides load and advance on that edge.
- R2: A rising edge with load_i high makes addr_o equal the start_i value present at that edge, and last_o 0 (beat count zero).
- R3: With order_i = 1 (interleaved), after n advances since the load, addr_o equals start XOR (n mod 4). For example, start 01 gives 01, 00, 11, 10.
- R4: With order_i = 0 (linear), after n advances since the load, addr_o equals (start + n) mod 4. For example, start 11 gives 11, 00, 01, 10.
- R5: A rising edge with load_i low and adv_i low leaves addr_o and last_o unchanged.
- R6: The advance after the fourth beat returns addr_o to the start offset and last_o to 0, and the four-address pattern then repeats.
- R7: When load_i and adv_i are both high at the same edge, the load wins: addr_o becomes the new start_i and the beat count restarts at zero.
- R8: last_o is 1 exactly when the beat count since the last load is 3 (the fourth beat), and 0 on all other beats.
- R9: Each advance without a load changes addr_o to a different value, in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Begin a new burst at start_i |
| start_i | input | 2 | Starting offset of the burst |
| adv_i | input | 1 | Step the burst by one beat |
| order_i | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| addr_o | output | 2 | Current low address bits of the burst |
| last_o | output | 1 | High on the fourth beat |

## Verification
Every result is due one rising edge after the stimulus that causes it: a load, an advance, a hold or a reset changes the registered start and beat count at that edge, and addr_o and last_o follow at once through combinational mapping. The bench drives its inputs just after a falling edge and samples the outputs at the next falling edge, so each check sees the state exactly one rising edge after its stimulus. The bench covers every start offset in both orders through six advances, which crosses the wrap point. Expected addresses are computed from the XOR or modulo-four sum of the start offset and the beat count.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] start_i,
    input  logic         adv_i,
    output logic [W-1:0] start_q_o,
    output logic [W-1:0] beat_q_o
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] start;
        logic [W-1:0] beat;
    } seq_state_t;

    seq_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.start = start_i;
            state_d.beat  = '0;
        end else if (adv_i) begin
            state_d.beat = state_q.beat + ONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign start_q_o = state_q.start;
    assign beat_q_o  = state_q.beat;

endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
    import burst_seq_pkg::*;
#(
    parameter int W = 2
) (
    input  logic         order_i,
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] beat_i,
    output logic [W-1:0] addr_o,
    output logic         last_o
);

    logic [W-1:0] ilv_addr;
    logic [W-1:0] lin_addr;

    for (genvar b = 0; b < W; b++) begin : g_ilv
        assign ilv_addr[b] = start_i[b] ^ beat_i[b];
    end

    assign lin_addr = start_i + beat_i;

    always_comb begin
        if (burst_order_e'(order_i) == ORD_INTERLEAVE) begin
            addr_o = ilv_addr;
        end else begin
            addr_o = lin_addr;
        end
    end

    assign last_o = &beat_i;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] start_i,
    input  logic         adv_i,
    input  logic         order_i,
    output logic [W-1:0] addr_o,
    output logic         last_o
);

    localparam int BEATS = 1 << W;

    logic [W-1:0] start_q;
    logic [W-1:0] beat_q;

    burst_seq_ctrl #(.W(W)) i_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .load_i    (load_i),
        .start_i   (start_i),
        .adv_i     (adv_i),
        .start_q_o (start_q),
        .beat_q_o  (beat_q)
    );

    burst_seq_map #(.W(W)) i_map (
        .order_i (order_i),
        .start_i (start_q),
        .beat_i  (beat_q),
        .addr_o  (addr_o),
        .last_o  (last_o)
    );

    initial begin
        if (BEATS < 2) $error("burst needs at least two beats");
    end

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int W = 2
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         load_i,
    input logic [W-1:0] start_i,
    input logic         adv_i,
    input logic         order_i,
    input logic [W-1:0] addr_o,
    input logic         last_o
);

    // R2
    load_capture_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (addr_o == $past(start_i)) && !last_o);

    // R5
    hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !adv_i) |=> ($stable(addr_o) && $stable(last_o)));

    // R6
    wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (last_o && adv_i && !load_i) |=> !last_o);

    // R9
    step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv_i && !load_i && $stable(order_i)) |=> (addr_o != $past(addr_o)));

    // R8
    last_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(last_o) |-> ($past(adv_i) && !$past(load_i)));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.W(W)) i_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .load_i  (load_i),
    .start_i (start_i),
    .adv_i   (adv_i),
    .order_i (order_i),
    .addr_o  (addr_o),
    .last_o  (last_o)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

    logic       clk = 1'b0;
    logic       rst;
    logic       load;
    logic [1:0] start;
    logic       adv;
    logic       order;
    logic [1:0] addr;
    logic       last;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq i_burst_addr_seq (
        .clk_i   (clk),
        .rst_i   (rst),
        .load_i  (load),
        .start_i (start),
        .adv_i   (adv),
        .order_i (order),
        .addr_o  (addr),
        .last_o  (last)
    );

    task automatic check(input string req, input logic [1:0] a_act, input logic [1:0] a_exp,
                         input logic l_act, input logic l_exp);
        n_chk++;
        if (a_act !== a_exp || l_act !== l_exp) begin
            n_fail++;
            $display("FAIL %s: addr=%b last=%b, expected addr=%b last=%b",
                     req, a_act, l_act, a_exp, l_exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic logic [1:0] exp_addr(input logic ord, input logic [1:0] s, input int n);
        logic [1:0] b;
        b = 2'(n % 4);
        return ord ? (s ^ b) : 2'(s + b);
    endfunction

    // one rising edge lies between drive and sample
    task automatic cyc();
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; load = 1'b0; start = 2'b00; adv = 1'b0; order = 1'b1;
        cyc(); cyc();
        // R1: reset state
        check("R1 reset", addr, 2'b00, last, 1'b0);
        rst = 1'b0;

        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 4; s++) begin
                order = o[0];
                load = 1'b1; start = 2'(s); adv = 1'b0;
                cyc();
                // R2: load captures the start offset
                check("R2 load", addr, 2'(s), last, 1'b0);
                load = 1'b0; adv = 1'b1;
                for (int k = 1; k <= 6; k++) begin
                    cyc();
                    // R3 interleaved / R4 linear / R8 last flag / R6 wrap
                    if (k == 4)
                        check("R6 wrap", addr, 2'(s), last, 1'b0);
                    else if (o == 1)
                        check("R3 interleaved", addr, exp_addr(1'b1, 2'(s), k), last, (k % 4) == 3);
                    else
                        check("R4 linear", addr, exp_addr(1'b0, 2'(s), k), last, (k % 4) == 3);
                end
                adv = 1'b0;
                for (int h = 0; h < 2; h++) begin
                    cyc();
                    // R5: hold while no advance
                    check("R5 hold", addr, exp_addr(o[0], 2'(s), 6), last, 1'b0);
                end
            end
        end

        // R8: hold on the fourth beat keeps last high
        order = 1'b0; load = 1'b1; start = 2'b10; adv = 1'b0;
        cyc();
        load = 1'b0; adv = 1'b1;
        cyc(); cyc(); cyc();
        check("R8 fourth beat", addr, 2'b01, last, 1'b1);
        adv = 1'b0;
        cyc();
        check("R8 held fourth beat", addr, 2'b01, last, 1'b1);

        // R7: load and advance together, load wins
        order = 1'b1; load = 1'b1; start = 2'b10; adv = 1'b0;
        cyc();
        load = 1'b0; adv = 1'b1;
        cyc(); cyc();
        check("R3 pre-priority", addr, 2'b00, last, 1'b0);
        load = 1'b1; start = 2'b01; adv = 1'b1;
        cyc();
        check("R7 load priority", addr, 2'b01, last, 1'b0);
        load = 1'b0;
        cyc(); cyc(); cyc();
        check("R7 restarted count", addr, 2'b10, last, 1'b1);

        // R1: reset mid-burst overrides load and advance
        adv = 1'b0;
        rst = 1'b1; load = 1'b1; start = 2'b11; adv = 1'b1;
        cyc();
        check("R1 reset override", addr, 2'b00, last, 1'b0);
        rst = 1'b0; load = 1'b0; adv = 1'b0;
        cyc();
        check("R1 after reset", addr, 2'b00, last, 1'b0);

        finish_run();
    end

endmodule